// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration space of a single function on a bus that is reached through configuration cycles. A requester presents one access at a time on a request port. The access carries a 24-bit address made of a bus number, a device/function number and a byte offset, plus a length code, a write flag and 32 bits of write data. When the bus and device/function fields match the block's own identity parameters, the access reaches the byte array. Otherwise reads return all ones, sized to the access, and writes are dropped.

Which bytes an ordinary write may change depends on the header-type byte held in the array. A 4-byte aligned write to a base register whose region size is nonzero does not take the byte path. Its value is trimmed to the region's size, and the region's type bits are put back. The expansion ROM register keeps its enable bit. A bridge variant starts from bridge reset values and captures the secondary bus number. The command word and the seven region registers are exported to an address window decoder. A one-cycle strobe tells that decoder when the command register has been written.

Control is a three-state machine. ST_IDLE accepts a request and raises `acc_ready`. The transition ST_IDLE to ST_RD_RSP happens on an accepted read. The transition ST_IDLE to ST_WR_CMT happens on an accepted write. From ST_RD_RSP (read data valid) and from ST_WR_CMT (mapping strobe if the command bytes were touched), the machine always returns to ST_IDLE on the next edge.

Top module: `cfg_space_regfile`

## Requirements
- R1: An access hits only when address bits 23:16 equal OWN_BUS and bits 15:8 equal OWN_DEVFN. Bits 7:0 give the byte offset.
- R2: A read that misses returns 0x000000FF for length code 0, 0x0000FFFF for length code 1, and 0xFFFFFFFF for length codes 2 and 3.
- R3: A hit read returns its bytes little-endian, with the byte at the offset in bits 7:0. Length code 2 or 3 reads 4 bytes only if the offset is at most 0xFC. Otherwise it reads 2 bytes if the offset is at most 0xFE, and otherwise 1 byte. Length code 1 reads 2 bytes only if the offset is at most 0xFE, and otherwise 1 byte. Bytes above the ones read are zero.
- R4: A write with length code 2 or 3, to a 4-aligned offset in 0x10–0x27 (region index = (offset−0x10)/4), to a region of nonzero size 2^S, stores the data with bits S−1:0 cleared and then ORed with that region's 4-bit type.
- R5: Such a write at offset 0x30 (ROM, region 6) clears bits S−1:1 and keeps bit 0 as written.
- R6: When the header byte at 0x0E holds 0x00 or 0x80, these bytes ignore byte-path writes: 0x00–0x03, 0x08–0x0B, 0x0E, 0x10–0x27, 0x30–0x33 and 0x3D.
- R7: When the header byte holds any other value, the byte-path read-only set is 0x00–0x03, 0x08–0x0B, 0x0E, 0x38–0x3B and 0x3D. Bytes 0x10–0x27 and 0x30–0x33 are writable.
- R8: A byte-path write covers 1, 2 or 4 bytes for length codes 0, 1 and 2/3. It stops after offset 0xFF and never wraps to offset 0x00.
- R9: In the bridge variant, a hit write whose byte range covers offset 0x19 loads `sec_bus` with the data byte for 0x19. All other accesses leave `sec_bus` unchanged.
- R10: The bridge variant resets to the following bytes: 0x04=0x06, 0x06=0xA0, 0x0A=0x04, 0x0B=0x06, 0x0D=0x10, 0x0E=0x81, 0x1E=0xA0. Bytes 0x00–0x03 hold the vendor and device identifiers.
- R11: A hit write whose range touches offset 0x04 or 0x05 raises `map_upd` for exactly one cycle, the cycle after acceptance (ST_WR_CMT). Other writes do not raise it.
- R12: A read is accepted in ST_IDLE. In the following cycle (ST_RD_RSP), `rd_valid` is high and `acc_ready` is low. The cycle after that returns to ST_IDLE.
- R13: A write that misses changes no byte of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access request, sampled only while acc_ready is high |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 24 | Bus number [23:16], device/function [15:8], offset [7:0] |
| acc_len | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| acc_wdata | input | 32 | Write data, byte at offset in bits 7:0 |
| acc_ready | output | 1 | High in ST_IDLE |
| rd_valid | output | 1 | Read data valid (ST_RD_RSP) |
| rd_data | output | 32 | Registered read data |
| cmd_reg | output | 16 | Command word, bytes 0x05:0x04 |
| bar_flat | output | 224 | Region registers 0–5 then ROM, 32 bits each |
| map_upd | output | 1 | One-cycle strobe after a command write |
| sec_bus | output | 8 | Captured secondary bus number (bridge only) |

## Verification
The bench pushes reads of every length against the top of the space. A design that clamps the length wrongly returns stale upper bytes, or reads past 0xFF. Base and ROM registers are written with all ones and with mixed patterns. Dropping the type bits, or clearing the ROM enable bit, shows up in the read-back and on `bar_flat`. Two instances with different header bytes take the same writes to base, ROM and identification offsets. A mask keyed to the wrong header type then lets a read-only byte change, or blocks a writable one. Misses with each length code and a missed write to the command bytes catch ones-padding of the wrong size and writes that leak through. Writes that straddle offset 0x04 or offset 0x19 catch a range test that only looks at the start offset.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int CFG_BYTES   = 256;
    localparam int NUM_REGIONS = 7;
    localparam int ROM_IDX     = NUM_REGIONS - 1;
    localparam int LANES       = 4;

    localparam logic [1:0] LEN_BYTE = 2'd0;
    localparam logic [1:0] LEN_HALF = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_RSP = 2'd1,
        ST_WR_CMT = 2'd2
    } acc_state_e;

    // number of bytes named by a length code (codes 2 and 3 both mean four)
    function automatic logic [2:0] len_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // offset of a region register in the space
    function automatic logic [7:0] region_off(input int k);
        if (k == ROM_IDX) return 8'h30;
        return 8'(8'h10 + 4 * k);
    endfunction

    // byte-path write protection keyed by the stored header byte
    function automatic logic byte_locked(input logic [7:0] hdr, input logic [7:0] a);
        logic common;
        common = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) ||
                 (a == 8'h0E) || (a == 8'h3D);
        if (hdr == 8'h00 || hdr == 8'h80)
            return common || (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
        return common || (a >= 8'h38 && a <= 8'h3B);
    endfunction
endpackage

// File: rtl/cfg_acc_fsm.sv
module cfg_acc_fsm
    import cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    input  logic acc_wr,
    input  logic cmd_touch,
    output logic acc_ready,
    output logic accept,
    output logic rd_valid,
    output logic map_upd
);
    acc_state_e state_q, state_d;
    logic       cmd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_req) state_d = acc_wr ? ST_WR_CMT : ST_RD_RSP;
            ST_RD_RSP: state_d = ST_IDLE;
            ST_WR_CMT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= accept & acc_wr & cmd_touch;
        end
    end

    always_comb begin
        acc_ready = 1'b0;
        rd_valid  = 1'b0;
        map_upd   = 1'b0;
        unique case (state_q)
            ST_IDLE:   acc_ready = 1'b1;
            ST_RD_RSP: rd_valid  = 1'b1;
            ST_WR_CMT: map_upd   = cmd_q;
            default:   ;
        endcase
    end

    assign accept = acc_ready & acc_req;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !acc_wr) |=> (rd_valid && !acc_ready));  // R12
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (!rd_valid && acc_ready));  // R12
    AST_MAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        map_upd |=> !map_upd);  // R11
endmodule

// File: rtl/cfg_wr_lanes.sv
module cfg_wr_lanes
    import cfg_pkg::*;
#(
    parameter bit                                IS_BRIDGE = 1'b0,
    parameter logic [NUM_REGIONS-1:0][4:0]       REG_SZLOG = '0,
    parameter logic [NUM_REGIONS-1:0][3:0]       REG_TYPE  = '0
) (
    input  logic [7:0]             off,
    input  logic [1:0]             len,
    input  logic [31:0]            wdata,
    input  logic [7:0]             hdr,
    output logic [LANES-1:0]       lane_en,
    output logic [LANES-1:0][7:0]  lane_addr,
    output logic [LANES-1:0][7:0]  lane_data,
    output logic                   cmd_touch,
    output logic                   sec_touch,
    output logic [7:0]             sec_val
);
    logic [2:0]  nbytes;
    logic [8:0]  end9;
    logic        in_bar, in_rom, region_path;
    logic [2:0]  ridx;
    logic [4:0]  szlog;
    logic [31:0] keep_mask, region_word;
    logic [7:0]  sdist;

    assign nbytes = len_bytes(len);
    assign end9   = {1'b0, off} + {6'd0, nbytes};

    // region (size-masked) path selection
    assign in_bar      = (off >= 8'h10) && (off <= 8'h27);
    assign in_rom      = (off >= 8'h30) && (off <= 8'h33);
    assign ridx        = in_rom ? 3'(ROM_IDX) : 3'((off - 8'h10) >> 2);
    assign szlog       = REG_SZLOG[ridx];
    assign region_path = len[1] && (off[1:0] == 2'b00) && (in_bar || in_rom) && (szlog != 5'd0);
    assign keep_mask   = 32'hFFFF_FFFF << szlog;

    always_comb begin
        if (in_rom) region_word = wdata & (keep_mask | 32'd1);
        else        region_word = (wdata & keep_mask) | {28'd0, REG_TYPE[ridx]};
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [8:0] a9;
        assign a9 = {1'b0, off} + 9'(l);
        always_comb begin
            lane_addr[l] = a9[7:0];
            if (region_path) begin
                lane_en[l]   = 1'b1;
                lane_data[l] = region_word[8*l +: 8];
            end else begin
                lane_en[l]   = (3'(l) < nbytes) && !a9[8] && !byte_locked(hdr, a9[7:0]);
                lane_data[l] = wdata[8*l +: 8];
            end
        end
    end

    // range tests against the command word and the secondary bus byte
    assign cmd_touch = (off < 8'h06) && (end9 > 9'd4);
    assign sec_touch = IS_BRIDGE && (off <= 8'h19) && (end9 > 9'h019);
    assign sdist     = 8'h19 - off;
    assign sec_val   = wdata[{sdist[1:0], 3'b000} +: 8];
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import cfg_pkg::*;
#(
    parameter bit                          IS_BRIDGE  = 1'b0,
    parameter logic [15:0]                 VENDOR_ID  = 16'h0000,
    parameter logic [15:0]                 DEVICE_ID  = 16'h0000,
    parameter logic [15:0]                 CLASS_CODE = 16'h0000,
    parameter logic [NUM_REGIONS-1:0][4:0] REG_SZLOG  = '0,
    parameter logic [NUM_REGIONS-1:0][3:0] REG_TYPE   = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [LANES-1:0]            lane_en,
    input  logic [LANES-1:0][7:0]       lane_addr,
    input  logic [LANES-1:0][7:0]       lane_data,
    input  logic [7:0]                  rd_off,
    input  logic [1:0]                  rd_len,
    output logic [31:0]                 rd_word,
    output logic [7:0]                  hdr_byte,
    output logic [15:0]                 cmd_word,
    output logic [NUM_REGIONS*32-1:0]   bar_flat
);
    logic [7:0] mem [CFG_BYTES];
    logic [2:0] rd_n;

    function automatic logic [7:0] rst_byte(input logic [7:0] a);
        logic [7:0] v;
        v = 8'h00;
        case (a)
            8'h00:   v = VENDOR_ID[7:0];
            8'h01:   v = VENDOR_ID[15:8];
            8'h02:   v = DEVICE_ID[7:0];
            8'h03:   v = DEVICE_ID[15:8];
            default: ;
        endcase
        if (IS_BRIDGE) begin
            case (a)
                8'h04:   v = 8'h06;
                8'h06:   v = 8'hA0;
                8'h0A:   v = 8'h04;
                8'h0B:   v = 8'h06;
                8'h0D:   v = 8'h10;
                8'h0E:   v = 8'h81;
                8'h1E:   v = 8'hA0;
                default: ;
            endcase
        end else begin
            if (a == 8'h0A) v = CLASS_CODE[7:0];
            if (a == 8'h0B) v = CLASS_CODE[15:8];
            for (int k = 0; k < NUM_REGIONS; k++)
                if (REG_SZLOG[k] != 5'd0 && a == region_off(k)) v = {4'h0, REG_TYPE[k]};
        end
        return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_BYTES; i++) mem[i] <= rst_byte(8'(i));
        end else if (we) begin
            for (int l = 0; l < LANES; l++)
                if (lane_en[l]) mem[lane_addr[l]] <= lane_data[l];
        end
    end

    // read width clamp near the top of the space
    always_comb begin
        if (rd_len[1] && rd_off <= 8'hFC)           rd_n = 3'd4;
        else if (rd_len != LEN_BYTE && rd_off <= 8'hFE) rd_n = 3'd2;
        else                                         rd_n = 3'd1;
        rd_word = '0;
        for (int i = 0; i < LANES; i++)
            if (3'(i) < rd_n) rd_word[8*i +: 8] = mem[rd_off + 8'(i)];
    end

    assign hdr_byte = mem[8'h0E];
    assign cmd_word = {mem[8'h05], mem[8'h04]};

    for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_bar
        localparam int ROFF = int'(region_off(k));
        assign bar_flat[k*32 +: 32] = {mem[ROFF+3], mem[ROFF+2], mem[ROFF+1], mem[ROFF]};
    end

    AST_HDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $stable(hdr_byte));  // R6
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
    import cfg_pkg::*;
#(
    parameter logic [7:0]                  OWN_BUS    = 8'h00,
    parameter logic [7:0]                  OWN_DEVFN  = 8'h00,
    parameter bit                          IS_BRIDGE  = 1'b0,
    parameter logic [15:0]                 VENDOR_ID  = 16'h1234,
    parameter logic [15:0]                 DEVICE_ID  = 16'h0001,
    parameter logic [15:0]                 CLASS_CODE = 16'h0200,
    parameter logic [NUM_REGIONS-1:0][4:0] REG_SZLOG  = '0,
    parameter logic [NUM_REGIONS-1:0][3:0] REG_TYPE   = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_req,
    input  logic                      acc_wr,
    input  logic [23:0]               acc_addr,
    input  logic [1:0]                acc_len,
    input  logic [31:0]               acc_wdata,
    output logic                      acc_ready,
    output logic                      rd_valid,
    output logic [31:0]               rd_data,
    output logic [15:0]               cmd_reg,
    output logic [NUM_REGIONS*32-1:0] bar_flat,
    output logic                      map_upd,
    output logic [7:0]                sec_bus
);
    logic                      hit, accept, we;
    logic [7:0]                off, hdr;
    logic [LANES-1:0]          lane_en;
    logic [LANES-1:0][7:0]     lane_addr, lane_data;
    logic                      cmd_touch, sec_touch;
    logic [7:0]                sec_val;
    logic [31:0]               rd_word, miss_ones;

    assign off = acc_addr[7:0];
    assign hit = (acc_addr[23:16] == OWN_BUS) && (acc_addr[15:8] == OWN_DEVFN);
    assign we  = accept & acc_wr & hit;

    cfg_acc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .acc_wr    (acc_wr),
        .cmd_touch (cmd_touch & hit),
        .acc_ready (acc_ready),
        .accept    (accept),
        .rd_valid  (rd_valid),
        .map_upd   (map_upd)
    );

    cfg_wr_lanes #(
        .IS_BRIDGE (IS_BRIDGE),
        .REG_SZLOG (REG_SZLOG),
        .REG_TYPE  (REG_TYPE)
    ) u_lanes (
        .off       (off),
        .len       (acc_len),
        .wdata     (acc_wdata),
        .hdr       (hdr),
        .lane_en   (lane_en),
        .lane_addr (lane_addr),
        .lane_data (lane_data),
        .cmd_touch (cmd_touch),
        .sec_touch (sec_touch),
        .sec_val   (sec_val)
    );

    cfg_store #(
        .IS_BRIDGE  (IS_BRIDGE),
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .CLASS_CODE (CLASS_CODE),
        .REG_SZLOG  (REG_SZLOG),
        .REG_TYPE   (REG_TYPE)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .lane_en   (lane_en),
        .lane_addr (lane_addr),
        .lane_data (lane_data),
        .rd_off    (off),
        .rd_len    (acc_len),
        .rd_word   (rd_word),
        .hdr_byte  (hdr),
        .cmd_word  (cmd_reg),
        .bar_flat  (bar_flat)
    );

    always_comb begin
        case (acc_len)
            2'd0:    miss_ones = 32'h0000_00FF;
            2'd1:    miss_ones = 32'h0000_FFFF;
            default: miss_ones = 32'hFFFF_FFFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            sec_bus <= '0;
        end else begin
            if (accept && !acc_wr) rd_data <= hit ? rd_word : miss_ones;
            if (we && sec_touch)   sec_bus <= sec_val;
        end
    end

    AST_MISS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !acc_wr && !hit && acc_len[1]) |=> (rd_data == 32'hFFFF_FFFF));  // R2
    AST_MISS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !acc_wr && !hit && acc_len == 2'd0) |=> (rd_data == 32'h0000_00FF));  // R2
    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_wr && !hit) |=> ($stable(cmd_reg) && $stable(bar_flat)));  // R13
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && acc_wr) |=> $stable(sec_bus));  // R9

    for (genvar k = 0; k < NUM_REGIONS - 1; k++) begin : g_bar_chk
        if (!IS_BRIDGE && REG_SZLOG[k] != 5'd0) begin : g_on
            localparam logic [31:0] LOWM = ~(32'hFFFF_FFFF << REG_SZLOG[k]);
            AST_BAR_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
                ((bar_flat[k*32 +: 32] & LOWM) == {28'd0, REG_TYPE[k]}));  // R4
        end
    end
endmodule

// File: tb/cfg_space_regfile_tb.sv
module cfg_space_regfile_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_n, req_ep, req_br, a_wr;
    logic [23:0] a_addr;
    logic [1:0]  a_len;
    logic [31:0] a_wd;

    logic        ep_ready, ep_rv, ep_map, br_ready, br_rv, br_map;
    logic [31:0] ep_rd, br_rd;
    logic [15:0] ep_cmd, br_cmd;
    logic [223:0] ep_bar, br_bar;
    logic [7:0]  ep_sec, br_sec;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] got_rd;
    logic got_valid, got_ready, got_map;

    cfg_space_regfile #(
        .OWN_BUS(8'h00), .OWN_DEVFN(8'h18), .IS_BRIDGE(1'b0),
        .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h7700), .CLASS_CODE(16'h0200),
        .REG_SZLOG({5'd16, 5'd0, 5'd0, 5'd0, 5'd0, 5'd5, 5'd12}),
        .REG_TYPE ({4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h8})
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_req(req_ep), .acc_wr(a_wr), .acc_addr(a_addr),
        .acc_len(a_len), .acc_wdata(a_wd), .acc_ready(ep_ready), .rd_valid(ep_rv),
        .rd_data(ep_rd), .cmd_reg(ep_cmd), .bar_flat(ep_bar), .map_upd(ep_map), .sec_bus(ep_sec)
    );

    cfg_space_regfile #(
        .OWN_BUS(8'h00), .OWN_DEVFN(8'h20), .IS_BRIDGE(1'b1),
        .VENDOR_ID(16'hA5A5), .DEVICE_ID(16'h0B01), .CLASS_CODE(16'h0000),
        .REG_SZLOG('0), .REG_TYPE('0)
    ) u_brg (
        .clk(clk), .rst_n(rst_n), .acc_req(req_br), .acc_wr(a_wr), .acc_addr(a_addr),
        .acc_len(a_len), .acc_wdata(a_wd), .acc_ready(br_ready), .rd_valid(br_rv),
        .rd_data(br_rd), .cmd_reg(br_cmd), .bar_flat(br_bar), .map_upd(br_map), .sec_bus(br_sec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access; outputs captured in the cycle after acceptance
    task automatic access(input bit to_br, input bit wr, input logic [23:0] addr,
                          input logic [1:0] len, input logic [31:0] wd);
        @(negedge clk);
        a_wr = wr; a_addr = addr; a_len = len; a_wd = wd;
        if (to_br) req_br = 1'b1; else req_ep = 1'b1;
        @(negedge clk);
        req_ep = 1'b0; req_br = 1'b0;
        got_rd    = to_br ? br_rd    : ep_rd;
        got_valid = to_br ? br_rv    : ep_rv;
        got_ready = to_br ? br_ready : ep_ready;
        got_map   = to_br ? br_map   : ep_map;
        @(negedge clk);
    endtask

    function automatic logic [23:0] ea(input logic [7:0] o); return {16'h0018, o}; endfunction
    function automatic logic [23:0] ba(input logic [7:0] o); return {16'h0020, o}; endfunction

    task automatic t_reset;
        access(0, 0, ea(8'h00), 2'd2, 0); chk("R3 ids le", got_rd, 32'h7700_C0DE);
        access(0, 0, ea(8'h0E), 2'd0, 0); chk("R6 hdr type0", got_rd, 32'h0);
        access(0, 0, ea(8'h10), 2'd2, 0); chk("R4 bar0 reset type", got_rd, 32'h8);
        access(0, 0, ea(8'h14), 2'd3, 0); chk("R4 bar1 reset type", got_rd, 32'h1);
    endtask

    task automatic t_fsm;
        access(0, 0, ea(8'h00), 2'd2, 0);
        chk("R12 rd_valid", {31'd0, got_valid}, 32'd1);
        chk("R12 ready low", {31'd0, got_ready}, 32'd0);
        chk("R12 back idle", {30'd0, ep_rv, ep_ready}, 32'd1);
    endtask

    task automatic t_miss;
        access(0, 0, {8'h01, 8'h18, 8'h00}, 2'd0, 0); chk("R2 miss len1", got_rd, 32'h0000_00FF);
        access(0, 0, {8'h01, 8'h18, 8'h00}, 2'd1, 0); chk("R2 miss len2", got_rd, 32'h0000_FFFF);
        access(0, 0, {8'h01, 8'h18, 8'h00}, 2'd2, 0); chk("R2 miss len4", got_rd, 32'hFFFF_FFFF);
        access(0, 0, {8'h00, 8'h19, 8'h00}, 2'd2, 0); chk("R1 devfn miss", got_rd, 32'hFFFF_FFFF);
        access(0, 0, {8'h00, 8'h18, 8'h00}, 2'd1, 0); chk("R1 hit", got_rd, 32'h0000_C0DE);
    endtask

    task automatic t_bar;
        access(0, 1, ea(8'h10), 2'd2, 32'hFFFF_FFFF);
        access(0, 0, ea(8'h10), 2'd2, 0); chk("R4 bar0 mask", got_rd, 32'hFFFF_F008);
        chk("R4 bar0 export", ep_bar[31:0], 32'hFFFF_F008);
        access(0, 1, ea(8'h14), 2'd2, 32'h0000_C0F3);
        access(0, 0, ea(8'h14), 2'd2, 0); chk("R4 bar1 io", got_rd, 32'h0000_C0E1);
        access(0, 1, ea(8'h18), 2'd2, 32'h1234_5678);
        access(0, 0, ea(8'h18), 2'd2, 0); chk("R6 empty bar locked", got_rd, 32'h0);
    endtask

    task automatic t_rom;
        access(0, 1, ea(8'h30), 2'd2, 32'hFFFF_FFFF);
        access(0, 0, ea(8'h30), 2'd2, 0); chk("R5 rom enable kept", got_rd, 32'hFFFF_0001);
        access(0, 1, ea(8'h30), 2'd2, 32'h1234_5678);
        chk("R5 rom export", ep_bar[6*32 +: 32], 32'h1234_0000);
    endtask

    task automatic t_ro_type0;
        access(0, 1, ea(8'h00), 2'd2, 32'hFFFF_FFFF);
        access(0, 0, ea(8'h00), 2'd2, 0); chk("R6 id locked", got_rd, 32'h7700_C0DE);
        access(0, 1, ea(8'h3C), 2'd1, 32'h0000_AB55);
        access(0, 0, ea(8'h3C), 2'd1, 0); chk("R6 3D locked", got_rd, 32'h0000_0055);
        access(0, 1, ea(8'h40), 2'd2, 32'hDEAD_BEEF);
        access(0, 0, ea(8'h40), 2'd2, 0); chk("R6 plain writable", got_rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_narrow;
        access(0, 1, ea(8'hFC), 2'd2, 32'h4433_2211);
        access(0, 0, ea(8'hFC), 2'd2, 0); chk("R3 word at FC", got_rd, 32'h4433_2211);
        access(0, 0, ea(8'hFD), 2'd2, 0); chk("R3 word at FD half", got_rd, 32'h0000_3322);
        access(0, 0, ea(8'hFF), 2'd2, 0); chk("R3 word at FF byte", got_rd, 32'h0000_0044);
        access(0, 0, ea(8'hFF), 2'd1, 0); chk("R3 half at FF byte", got_rd, 32'h0000_0044);
        access(0, 1, ea(8'hFE), 2'd2, 32'hAABB_CCDD);
        access(0, 0, ea(8'hFE), 2'd1, 0); chk("R8 top write", got_rd, 32'h0000_CCDD);
        access(0, 0, ea(8'hFC), 2'd1, 0); chk("R8 below untouched", got_rd, 32'h0000_2211);
    endtask

    task automatic t_cmd;
        access(0, 1, ea(8'h04), 2'd1, 32'h0000_0007);
        chk("R11 strobe", {31'd0, got_map}, 32'd1);
        chk("R11 cmd value", {16'd0, ep_cmd}, 32'h0007);
        chk("R11 strobe one cycle", {31'd0, ep_map}, 32'd0);
        access(0, 1, ea(8'h06), 2'd1, 32'h0000_1234);
        chk("R11 no strobe", {31'd0, got_map}, 32'd0);
        access(0, 1, ea(8'h03), 2'd1, 32'h0000_1500);
        chk("R11 straddle strobe", {31'd0, got_map}, 32'd1);
        chk("R11 straddle cmd", {16'd0, ep_cmd}, 32'h0015);
    endtask

    task automatic t_miss_write;
        access(0, 1, {8'h00, 8'h19, 8'h40}, 2'd2, 32'h0);
        access(0, 0, ea(8'h40), 2'd2, 0); chk("R13 miss write dropped", got_rd, 32'hDEAD_BEEF);
        access(0, 1, {8'h02, 8'h18, 8'h04}, 2'd1, 32'hFFFF);
        chk("R13 miss no strobe", {31'd0, got_map}, 32'd0);
        chk("R13 miss cmd kept", {16'd0, ep_cmd}, 32'h0015);
    endtask

    task automatic t_bridge;
        chk("R10 cmd reset", {16'd0, br_cmd}, 32'h0006);
        access(1, 0, ba(8'h04), 2'd2, 0); chk("R10 cmd/status", got_rd, 32'h00A0_0006);
        access(1, 0, ba(8'h08), 2'd2, 0); chk("R10 class", got_rd, 32'h0604_0000);
        access(1, 0, ba(8'h0C), 2'd2, 0); chk("R10 hdr/lat", got_rd, 32'h0081_1000);
        access(1, 0, ba(8'h1C), 2'd2, 0); chk("R10 sec status", got_rd, 32'h00A0_0000);
        access(1, 1, ba(8'h38), 2'd2, 32'hFFFF_FFFF);
        access(1, 0, ba(8'h38), 2'd2, 0); chk("R7 rom range locked", got_rd, 32'h0);
        access(1, 1, ba(8'h30), 2'd2, 32'h1234_5678);
        access(1, 0, ba(8'h30), 2'd2, 0); chk("R7 30 writable", got_rd, 32'h1234_5678);
        access(1, 1, ba(8'h10), 2'd2, 32'hCAFE_0001);
        access(1, 0, ba(8'h10), 2'd2, 0); chk("R7 10 writable", got_rd, 32'hCAFE_0001);
        access(1, 1, ba(8'h0E), 2'd0, 32'h0);
        access(1, 0, ba(8'h0E), 2'd0, 0); chk("R7 hdr locked", got_rd, 32'h81);
    endtask

    task automatic t_secbus;
        chk("R9 sec reset", {24'd0, br_sec}, 32'h0);
        access(1, 1, ba(8'h18), 2'd2, 32'h0020_0500);
        chk("R9 sec word", {24'd0, br_sec}, 32'h05);
        access(1, 0, ba(8'h18), 2'd2, 0); chk("R9 bytes stored", got_rd, 32'h0020_0500);
        access(1, 1, ba(8'h19), 2'd0, 32'h07);
        chk("R9 sec byte", {24'd0, br_sec}, 32'h07);
        access(1, 1, ba(8'h17), 2'd2, 32'h4433_0900);
        chk("R9 sec straddle", {24'd0, br_sec}, 32'h33);
        access(1, 1, ba(8'h18), 2'd0, 32'hAA);
        chk("R9 sec untouched", {24'd0, br_sec}, 32'h33);
        access(1, 1, {8'h00, 8'h21, 8'h19}, 2'd0, 32'h99);
        chk("R9 miss no capture", {24'd0, br_sec}, 32'h33);
    endtask

    initial begin
        rst_n = 1'b0; req_ep = 1'b0; req_br = 1'b0; a_wr = 1'b0;
        a_addr = '0; a_len = '0; a_wd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 ready after reset", {30'd0, ep_rv, ep_ready}, 32'd1);
        t_reset;
        t_fsm;
        t_miss;
        t_bar;
        t_rom;
        t_ro_type0;
        t_narrow;
        t_cmd;
        t_miss_write;
        t_bridge;
        t_secbus;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R12 actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule